// File: doc/BRIEF.md
# Carrier-Locked Control Interrupt Source

This block paces a processor's control loop from the edges of a PWM carrier instead of from a free-running timer. It receives one-cycle strobes for the carrier peak and the carrier valley, keeps the ones the qualifier selects, and divides them by a programmable ratio. Each time the count completes, it issues a one-cycle trigger that starts a new acquisition on the attached sensors. It also reports an aggregate completion flag and raises a one-cycle interrupt toward the scheduler.

There are two interrupt sources. In direct mode the interrupt follows each trigger. In synchronised mode the interrupt waits until every enabled sensor has finished the acquisition the trigger started. If no sensor is enabled, synchronised mode behaves exactly like direct mode. A trigger is held back while any enabled sensor is still busy, so an acquisition is never restarted before it completes. Sensors are expected to come out of reset with their done flag high, so the first trigger is not blocked.

The interrupt source is a two-state machine. In `ST_IDLE`, a trigger in direct mode produces an interrupt and the machine stays in `ST_IDLE`. In `ST_IDLE`, a trigger in synchronised mode moves the machine to `ST_ARMED`. In `ST_ARMED`, a rising edge of the aggregate done flag produces an interrupt and the machine returns to `ST_IDLE`. In `ST_ARMED`, a switch to direct behaviour (mode change, or all sensors disabled) returns the machine to `ST_IDLE`; if a trigger is present in that same cycle, it also produces an interrupt.

Top module: `sched_irq_gen`

## Requirements
- R1: The qualifier register at address 2 selects which carrier strobes are counted: 0 counts valleys only, 1 counts peaks only, 2 or 3 counts both. Strobes that are not selected have no effect on the count.
- R2: The ratio register at address 0 sets N. On the N-th counted strobe, `sensor_trig_o` is high during the clock cycle that follows the edge at which that strobe was sampled. The counter then restarts from zero.
- R3: A ratio of 0 behaves as a ratio of 1: every counted strobe issues a trigger.
- R4: Any write to the ratio register clears the event counter, so the next trigger needs a full N counted strobes after the write.
- R5: A trigger is issued only when `all_done_o` is high at the counted strobe. When the count is complete but `all_done_o` is low, the counter holds at its limit, and the next counted strobe that sees `all_done_o` high issues the trigger.
- R6: `all_done_o` is the AND, over all sensors, of (done OR NOT enabled), where the enable mask is the register at address 3 (bit i enables sensor i). It is high whenever no sensor is enabled.
- R7: In direct mode (mode register at address 1 equal to 0), `sched_irq_o` is high in the cycle after each trigger, whatever the sensor flags do.
- R8: In synchronised mode (mode register equal to 1) with at least one sensor enabled, a trigger alone raises no interrupt. `sched_irq_o` is high in the cycle after the first clock edge at which `all_done_o` is high and was low at the previous edge, provided a trigger came before. A rise of `all_done_o` with no trigger before it raises nothing.
- R9: In synchronised mode with the enable mask equal to zero, the interrupt follows each trigger exactly as in R7.
- R10: `sensor_trig_o` and `sched_irq_o` are single-cycle pulses.
- R11: Synchronous active-high reset sets ratio 10, mode 0, qualifier 0 (valleys) and enable mask 0, clears the counter, and leaves both pulse outputs low.
- R12: `cfg_rdata_o` returns, zero-extended and without a clock delay, the register selected by `cfg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_peak_i | input | 1 | One-cycle strobe at the carrier maximum |
| carrier_valley_i | input | 1 | One-cycle strobe at the carrier minimum |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| cfg_rdata_o | output | DATA_W | Read data of the selected register |
| sensor_done_i | input | N_SENSORS | Per-sensor acquisition complete flags |
| sensor_trig_o | output | 1 | One-cycle acquisition start pulse |
| all_done_o | output | 1 | Every enabled sensor has finished |
| sched_irq_o | output | 1 | One-cycle scheduler interrupt |

## Verification
The pulse-width assertions assume that carrier strobes, counting peaks and valleys together, never arrive in two consecutive cycles. A real carrier spaces them by many cycles, and the bench always leaves at least one idle cycle between strobes. The synchronised-mode assertion relies on the done flags being settled at the clock edge, so the bench drives every input on the falling edge. Sensor done flags start high and fall only after a trigger, as a real acquisition engine would behave.

// File: rtl/sched_irq_pkg.sv
package sched_irq_pkg;

    typedef enum logic [1:0] {
        QUAL_VALLEY   = 2'd0,
        QUAL_PEAK     = 2'd1,
        QUAL_BOTH     = 2'd2,
        QUAL_BOTH_ALT = 2'd3
    } qual_e;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_SYNC   = 1'b1
    } src_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } irq_state_e;

    localparam logic [1:0] ADDR_RATIO = 2'd0;
    localparam logic [1:0] ADDR_MODE  = 2'd1;
    localparam logic [1:0] ADDR_QUAL  = 2'd2;
    localparam logic [1:0] ADDR_EN    = 2'd3;

endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
    import sched_irq_pkg::*;
#(
    parameter int N_SENSORS     = 4,
    parameter int RATIO_W       = 16,
    parameter int DATA_W        = 16,
    parameter int DEFAULT_RATIO = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [1:0]           addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [RATIO_W-1:0]   ratio_o,
    output logic                 ratio_wr_o,
    output src_mode_e            mode_o,
    output qual_e                qual_o,
    output logic [N_SENSORS-1:0] en_o
);

    // Registered configuration fields
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_o <= RATIO_W'(DEFAULT_RATIO);
            mode_o  <= MODE_DIRECT;
            qual_o  <= QUAL_VALLEY;
            en_o    <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADDR_RATIO: ratio_o <= wdata_i[RATIO_W-1:0];
                ADDR_MODE:  mode_o  <= src_mode_e'(wdata_i[0]);
                ADDR_QUAL:  qual_o  <= qual_e'(wdata_i[1:0]);
                default:    en_o    <= wdata_i[N_SENSORS-1:0];
            endcase
        end
    end

    // Write strobe that restarts the event counter
    assign ratio_wr_o = we_i && (addr_i == ADDR_RATIO);

    // Read path: zero-extended and combinational
    always_comb begin
        case (addr_i)
            ADDR_RATIO: rdata_o = DATA_W'(ratio_o);
            ADDR_MODE:  rdata_o = DATA_W'(mode_o);
            ADDR_QUAL:  rdata_o = DATA_W'(qual_o);
            default:    rdata_o = DATA_W'(en_o);
        endcase
    end

endmodule

// File: rtl/event_decimator.sv
module event_decimator
    import sched_irq_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               peak_i,
    input  logic               valley_i,
    input  qual_e              qual_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               clr_i,
    input  logic               all_done_i,
    output logic               trigger_o
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] cnt_d;
    logic [RATIO_W-1:0] limit;
    logic               counted;
    logic               hit;

    // Strobe qualification
    always_comb begin
        unique case (qual_i)
            QUAL_VALLEY: counted = valley_i;
            QUAL_PEAK:   counted = peak_i;
            QUAL_BOTH,
            QUAL_BOTH_ALT: counted = valley_i | peak_i;
        endcase
    end

    // A ratio of zero counts as one
    assign limit = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;

    always_comb begin
        hit   = 1'b0;
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (counted) begin
            if (cnt_q >= limit - 1'b1) begin
                if (all_done_i) begin
                    hit   = 1'b1;
                    cnt_d = '0;
                end
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            trigger_o <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            trigger_o <= hit;
        end
    end

    // R5: a trigger requires completion at the strobe that issued it
    a_r5_trigger_needs_done: assert property (@(posedge clk) disable iff (rst)
        trigger_o |-> $past(all_done_i));

    // R2: a trigger always follows a counted strobe
    a_r2_trigger_after_event: assert property (@(posedge clk) disable iff (rst)
        trigger_o |-> $past(counted));

    // R10: trigger is a single-cycle pulse
    a_r10_trigger_single: assert property (@(posedge clk) disable iff (rst)
        trigger_o |=> !trigger_o);

endmodule

// File: rtl/done_aggregator.sv
module done_aggregator #(
    parameter int N_SENSORS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SENSORS-1:0] done_i,
    input  logic [N_SENSORS-1:0] en_i,
    output logic                 all_done_o,
    output logic                 rise_o
);

    logic                 prev_q;
    logic [N_SENSORS-1:0] ready;

    // A disabled sensor never holds completion low
    for (genvar s = 0; s < N_SENSORS; s++) begin : g_ready
        assign ready[s] = done_i[s] | ~en_i[s];
    end

    assign all_done_o = &ready;

    // Previous value starts high so reset release is not seen as an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= all_done_o;
    end

    assign rise_o = all_done_o & ~prev_q;

    // R6: completion edge lasts one cycle
    a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/irq_source_fsm.sv
module irq_source_fsm
    import sched_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trigger_i,
    input  logic rise_i,
    input  logic direct_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       irq_d;

    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trigger_i) begin
                    if (direct_i) irq_d   = 1'b1;
                    else          state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (direct_i) begin
                    state_d = ST_IDLE;
                    irq_d   = trigger_i;
                end else if (rise_i) begin
                    state_d = ST_IDLE;
                    irq_d   = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= irq_d;
    end

    // R7 / R9: a direct-mode trigger raises the interrupt next cycle
    a_r7_direct_irq: assert property (@(posedge clk) disable iff (rst)
        (trigger_i && direct_i) |=> irq_o);

    // R8: in synchronised mode the interrupt comes from a completion edge
    a_r8_sync_from_edge: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !$past(direct_i)) |-> $past(rise_i));

    // R10: interrupt is a single-cycle pulse
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

endmodule

// File: rtl/sched_irq_gen.sv
module sched_irq_gen
    import sched_irq_pkg::*;
#(
    parameter int N_SENSORS     = 4,
    parameter int RATIO_W       = 16,
    parameter int DATA_W        = 16,
    parameter int DEFAULT_RATIO = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 carrier_peak_i,
    input  logic                 carrier_valley_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_addr_i,
    input  logic [DATA_W-1:0]    cfg_wdata_i,
    output logic [DATA_W-1:0]    cfg_rdata_o,
    input  logic [N_SENSORS-1:0] sensor_done_i,
    output logic                 sensor_trig_o,
    output logic                 all_done_o,
    output logic                 sched_irq_o
);

    logic [RATIO_W-1:0]   ratio;
    logic                 ratio_wr;
    src_mode_e            mode;
    qual_e                qual;
    logic [N_SENSORS-1:0] en;
    logic                 done_rise;
    logic                 direct;

    sched_cfg_regs #(
        .N_SENSORS    (N_SENSORS),
        .RATIO_W      (RATIO_W),
        .DATA_W       (DATA_W),
        .DEFAULT_RATIO(DEFAULT_RATIO)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .ratio_o   (ratio),
        .ratio_wr_o(ratio_wr),
        .mode_o    (mode),
        .qual_o    (qual),
        .en_o      (en)
    );

    done_aggregator #(
        .N_SENSORS(N_SENSORS)
    ) u_done (
        .clk       (clk),
        .rst       (rst),
        .done_i    (sensor_done_i),
        .en_i      (en),
        .all_done_o(all_done_o),
        .rise_o    (done_rise)
    );

    event_decimator #(
        .RATIO_W(RATIO_W)
    ) u_decim (
        .clk       (clk),
        .rst       (rst),
        .peak_i    (carrier_peak_i),
        .valley_i  (carrier_valley_i),
        .qual_i    (qual),
        .ratio_i   (ratio),
        .clr_i     (ratio_wr),
        .all_done_i(all_done_o),
        .trigger_o (sensor_trig_o)
    );

    // Synchronised mode with no sensor enabled falls back to direct
    assign direct = (mode == MODE_DIRECT) || (en == '0);

    irq_source_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trigger_i(sensor_trig_o),
        .rise_i   (done_rise),
        .direct_i (direct),
        .irq_o    (sched_irq_o)
    );

endmodule

// File: tb/test_sched_irq_gen.sv
module test_sched_irq_gen;

    localparam int N  = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          peak, valley;
    logic          we;
    logic [1:0]    addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [N-1:0]  done;
    logic          trig, alldone, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sched_irq_gen #(.N_SENSORS(N), .DATA_W(DW)) i_sched_irq_gen (
        .clk             (clk),
        .rst             (rst),
        .carrier_peak_i  (peak),
        .carrier_valley_i(valley),
        .cfg_we_i        (we),
        .cfg_addr_i      (addr),
        .cfg_wdata_i     (wdata),
        .cfg_rdata_o     (rdata),
        .sensor_done_i   (done),
        .sensor_trig_o   (trig),
        .all_done_o      (alldone),
        .sched_irq_o     (irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        we = 1'b1; addr = a; wdata = DW'(d);
        step();
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        addr = a;
        #1;
        chk(req, int'(rdata), exp);
    endtask

    // One strobe, check the trigger, then one idle cycle
    task automatic evt(input logic p, input logic v, input int exp_trig, input string req);
        peak = p; valley = v;
        step();
        peak = 1'b0; valley = 1'b0;
        chk(req, int'(trig), exp_trig);
        step();
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 10, "R11 ratio");
        rd_chk(2'd1, 0, "R11 mode");
        rd_chk(2'd2, 0, "R11 qual");
        rd_chk(2'd3, 0, "R11 enable");
        chk("R11 trig", int'(trig), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R6 alldone no enables", int'(alldone), 1);
    endtask

    task automatic t_default_ratio();
        for (int i = 0; i < 9; i++) evt(1'b0, 1'b1, 0, "R2 below count");
        evt(1'b0, 1'b1, 1, "R2 tenth valley");
        chk("R10 trig single", int'(trig), 0);
        chk("R7 irq after trig", int'(irq), 1);
        step();
        chk("R10 irq single", int'(irq), 0);
    endtask

    task automatic t_qualifier();
        wr(2'd0, 1);
        evt(1'b1, 1'b0, 0, "R1 peak ignored in valley mode");
        evt(1'b0, 1'b1, 1, "R1 valley counted");
        wr(2'd2, 1);
        evt(1'b0, 1'b1, 0, "R1 valley ignored in peak mode");
        evt(1'b1, 1'b0, 1, "R1 peak counted");
        wr(2'd2, 2);
        evt(1'b1, 1'b0, 1, "R1 both peak");
        evt(1'b0, 1'b1, 1, "R1 both valley");
        rd_chk(2'd2, 2, "R12 qual readback");
    endtask

    task automatic t_ratio_zero();
        wr(2'd0, 0);
        rd_chk(2'd0, 0, "R12 ratio readback");
        for (int i = 0; i < 3; i++) evt(1'b1, 1'b0, 1, "R3 ratio zero");
    endtask

    task automatic t_ratio_clear();
        wr(2'd0, 3);
        evt(1'b1, 1'b0, 0, "R4 first");
        evt(1'b1, 1'b0, 0, "R4 second");
        wr(2'd0, 3);
        evt(1'b1, 1'b0, 0, "R4 after clear 1");
        evt(1'b1, 1'b0, 0, "R4 after clear 2");
        evt(1'b1, 1'b0, 1, "R4 after clear 3");
    endtask

    task automatic t_done_gate();
        wr(2'd0, 1);
        wr(2'd3, 1);
        done = 4'b1110;
        #1;
        chk("R6 enabled busy", int'(alldone), 0);
        step();
        evt(1'b1, 1'b0, 0, "R5 blocked while busy");
        done = 4'b1111;
        #1;
        chk("R6 enabled done", int'(alldone), 1);
        step();
        evt(1'b1, 1'b0, 1, "R5 released");
        wr(2'd3, 0);
        done = 4'b0000;
        #1;
        chk("R6 disabled sensors", int'(alldone), 1);
        done = 4'b1111;
        step();
    endtask

    task automatic t_direct_ignores_sensors();
        wr(2'd3, 1);
        peak = 1'b1;
        step();
        peak = 1'b0;
        chk("R2 trig", int'(trig), 1);
        done = 4'b1110;
        step();
        chk("R7 irq despite busy", int'(irq), 1);
        done = 4'b1111;
        step(); step();
    endtask

    task automatic t_sync_mode();
        wr(2'd1, 1);
        evt(1'b1, 1'b0, 1, "R8 trig");
        chk("R8 no irq from trigger", int'(irq), 0);
        done = 4'b1110;
        step();
        chk("R8 no irq while busy", int'(irq), 0);
        step();
        chk("R8 alldone low", int'(alldone), 0);
        done = 4'b1111;
        step();
        chk("R8 irq on completion", int'(irq), 1);
        step();
        chk("R10 irq single sync", int'(irq), 0);
        done = 4'b1110;
        step(); step();
        done = 4'b1111;
        step();
        chk("R8 no irq without trigger", int'(irq), 0);
        step();
        chk("R8 still no irq", int'(irq), 0);
    endtask

    task automatic t_sync_no_sensors();
        wr(2'd3, 0);
        rd_chk(2'd1, 1, "R12 mode readback");
        evt(1'b1, 1'b0, 1, "R9 trig");
        chk("R9 irq like direct", int'(irq), 1);
        step();
    endtask

    initial begin
        rst = 1'b1; peak = 1'b0; valley = 1'b0;
        we = 1'b0; addr = '0; wdata = '0; done = '1;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_default_ratio();
        t_qualifier();
        t_ratio_zero();
        t_ratio_clear();
        t_done_gate();
        t_direct_ignores_sensors();
        t_sync_mode();
        t_sync_no_sensors();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule